// File: doc/BRIEF.md
# Serial EEPROM Slave Emulator

This block behaves toward an SPI master like a 512-byte serial EEPROM. The master selects it with an active-low chip select, sends an 8-bit instruction, usually an 8-bit address, and then either streams data out of the storage array or loads data to be written. The interface runs in SPI mode 0. The block samples the serial input on the rising serial-clock edge. It drives the serial output on the falling edge, together with an output-enable that an I/O cell can use to tri-state the line. All SPI pins are resynchronised into the system clock domain. The serial clock must therefore be several times slower than the system clock.

A 512-byte address is one bit wider than the address byte. The top address bit travels in bit 3 of the read and write instructions. Reads increment through the whole array and wrap from the top back to zero. A write must be unlocked first by a write-enable instruction sent in its own selection. Written bytes collect in a 16-entry page buffer, and only the low four address bits advance. The buffer is copied into storage only when chip select rises exactly after the last bit of a complete data byte. During that commit, a busy flag stays high for a parameterised number of system clocks. While busy, only status reads are served.

Top module: `seeprom_slave`

## Requirements
- R1: After reset the serial output enable is low and a status read returns 0x00.
- R2: Instruction 0x05 returns the status byte repeatedly: bit 0 is the busy flag, bit 1 the write-enable latch, and the other bits are 0.
- R3: Instruction 0x06 sets the write-enable latch only when chip select rises right after those 8 bits. A write that follows the enable in the same selection is ignored and leaves the latch clear.
- R4: Instruction 0000_A011 followed by address byte D reads from address {A,D}. Data is sent MSB first, and each bit changes on a falling serial-clock edge.
- R5: Continued clocking during a read returns consecutive addresses, wrapping from 0x1FF to 0x000.
- R6: Instruction 0000_A010 with address {A,D} buffers data bytes at addresses whose upper five bits stay fixed while the low four bits count modulo 16. A later byte at the same slot replaces an earlier one.
- R7: A write is committed only if chip select rises after a whole number (at least one) of data bytes. Any other rise discards the buffer and clears the write-enable latch.
- R8: A commit holds the busy flag high for exactly WIP_CYCLES system clocks and clears the write-enable latch.
- R9: While busy, read, write and write-enable instructions are ignored, and status reads still work.
- R10: The output enable is low whenever chip select is high and whenever no read or status data is being returned.
- R11: A write instruction with the write-enable latch clear is ignored and changes no storage.
- R12: Any other instruction byte is ignored until chip select rises, and it leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_sdi | input | 1 | Serial data from the master |
| spi_sdo | output | 1 | Serial data to the master |
| spi_sdo_oe | output | 1 | Output enable for the serial data pin |

## Verification
The bound checker watches on every cycle that the busy window has exactly the configured length, and that a commit clears the latch and raises busy. It also checks that no read or write address phase runs while busy, that the serial output moves only on a falling clock or a new selection, that buffered bytes only land while the latch is set, and that the output enable drops after deselection. Only the bench scenarios can show the data itself: the 9-bit addressing through the opcode, the full-array wrap, the in-page wrap with overwrite, and the accept or discard outcome of each chip-select release position. Those outcomes are compared against a byte-level model of the array kept in the bench.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_RADDR,
    ST_RDATA,
    ST_WADDR,
    ST_WDATA,
    ST_STAT,
    ST_SKIP
  } seep_state_e;

  localparam logic [7:0] OPC_WEN  = 8'h06;
  localparam logic [7:0] OPC_STAT = 8'h05;
  localparam logic [2:0] OPC_RD_LO = 3'b011;
  localparam logic [2:0] OPC_WR_LO = 3'b010;
endpackage

// File: rtl/seeprom_sync.sv
module seeprom_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/seeprom_busy.sv
module seeprom_busy #(
  parameter int WIP_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WIP_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) cnt_d = CW'(WIP_CYCLES);
    else if (cnt_q != '0) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/seeprom_store.sv
module seeprom_store #(
  parameter int DEPTH = 512,
  parameter int PAGE  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(PAGE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_clr,
  input  logic          buf_we,
  input  logic [PW-1:0] buf_idx,
  input  logic [7:0]    buf_din,
  input  logic          commit,
  input  logic [AW-PW-1:0] page_sel,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          buf_any
);
  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];
  logic [PAGE-1:0] pval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pval <= '0;
    else if (buf_clr) pval <= '0;
    else if (buf_we)  pval[buf_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_din;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (pval[i]) mem[{page_sel, PW'(i)}] <= pbuf[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];
  assign buf_any = |pval;
endmodule

// File: rtl/seeprom_slave.sv
module seeprom_slave
  import seeprom_pkg::*;
#(
  parameter int DEPTH      = 512,
  parameter int PAGE       = 16,
  parameter int WIP_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_sdi,
  output logic spi_sdo,
  output logic spi_sdo_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);

  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic [2:0] pins_s;
  logic       cs_s, sck_s, sdi_s;
  logic       cs_prev, sck_prev;
  logic       cs_rise, cs_fall, sck_rise, sck_fall;

  seeprom_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .din  ({spi_cs_n, spi_sck, spi_sdi}),
    .dout (pins_s)
  );
  assign {cs_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_prev  <= cs_s;
      sck_prev <= sck_s;
    end
  end
  assign cs_rise  =  cs_s & ~cs_prev;
  assign cs_fall  = ~cs_s &  cs_prev;
  assign sck_rise =  sck_s & ~sck_prev;
  assign sck_fall = ~sck_s &  sck_prev;

  seep_state_e   st, st_n;
  logic [2:0]    bcnt, bcnt_n;
  logic [6:0]    rx, rx_n;
  logic [AW-1:0] addr, addr_n;
  logic [7:0]    osh, osh_n;
  logic [2:0]    ocnt, ocnt_n;
  logic          sdo_q, sdo_n;
  logic          wel, wel_n;
  logic          wren_p, wren_n;

  logic          wip, commit, buf_we, buf_clr, buf_any;
  logic [7:0]    rx_byte, status, rd_data;
  logic [AW-1:0] rd_addr;

  assign rx_byte = {rx, sdi_s};
  assign status  = {6'b000000, wel, wip};
  assign rd_addr = (st == ST_RADDR) ? {addr[AW-1], rx_byte} : addr;

  always_comb begin
    st_n    = st;
    bcnt_n  = bcnt;
    rx_n    = rx;
    addr_n  = addr;
    osh_n   = osh;
    ocnt_n  = ocnt;
    sdo_n   = sdo_q;
    wel_n   = wel;
    wren_n  = wren_p;
    buf_we  = 1'b0;
    buf_clr = 1'b0;
    commit  = 1'b0;
    if (cs_fall) begin
      st_n    = ST_CMD;
      bcnt_n  = '0;
      ocnt_n  = '0;
      sdo_n   = 1'b0;
      wren_n  = 1'b0;
      buf_clr = 1'b1;
    end else if (cs_rise) begin
      st_n   = ST_IDLE;
      wren_n = 1'b0;
      if (wren_p && bcnt == '0) wel_n = 1'b1;
      if (st == ST_WDATA && bcnt == '0 && buf_any) begin
        commit = 1'b1;
        wel_n  = 1'b0;
      end else if (st == ST_WADDR || st == ST_WDATA) begin
        wel_n = 1'b0;
      end
    end else if (!cs_s && sck_rise && st != ST_IDLE) begin
      rx_n   = rx_byte[6:0];
      bcnt_n = bcnt + 3'd1;
      if (bcnt == 3'd7) begin
        wren_n = 1'b0;
        case (st)
          ST_CMD: begin
            st_n = ST_SKIP;
            if (rx_byte == OPC_STAT) begin
              st_n  = ST_STAT;
              osh_n = status;
            end else if (!wip && rx_byte == OPC_WEN) begin
              wren_n = 1'b1;
            end else if (!wip && rx_byte[7:4] == 4'h0 && rx_byte[2:0] == OPC_RD_LO) begin
              st_n = ST_RADDR;
              addr_n[AW-1] = rx_byte[3];
            end else if (!wip && wel && rx_byte[7:4] == 4'h0 && rx_byte[2:0] == OPC_WR_LO) begin
              st_n = ST_WADDR;
              addr_n[AW-1] = rx_byte[3];
            end
          end
          ST_RADDR: begin
            st_n   = ST_RDATA;
            osh_n  = rd_data;
            addr_n = rd_addr + AW'(1);
          end
          ST_WADDR: begin
            st_n   = ST_WDATA;
            addr_n = {addr[AW-1], rx_byte};
          end
          ST_WDATA: begin
            buf_we = 1'b1;
            addr_n = {addr[AW-1:PW], addr[PW-1:0] + PW'(1)};
          end
          default: ;
        endcase
      end
    end else if (!cs_s && sck_fall && (st == ST_RDATA || st == ST_STAT)) begin
      sdo_n = osh[7];
      if (ocnt == 3'd7) begin
        ocnt_n = '0;
        if (st == ST_RDATA) begin
          osh_n  = rd_data;
          addr_n = addr + AW'(1);
        end else begin
          osh_n = status;
        end
      end else begin
        ocnt_n = ocnt + 3'd1;
        osh_n  = {osh[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st     <= ST_IDLE;
      bcnt   <= '0;
      rx     <= '0;
      addr   <= '0;
      osh    <= '0;
      ocnt   <= '0;
      sdo_q  <= 1'b0;
      wel    <= 1'b0;
      wren_p <= 1'b0;
    end else begin
      st     <= st_n;
      bcnt   <= bcnt_n;
      rx     <= rx_n;
      addr   <= addr_n;
      osh    <= osh_n;
      ocnt   <= ocnt_n;
      sdo_q  <= sdo_n;
      wel    <= wel_n;
      wren_p <= wren_n;
    end
  end

  seeprom_store #(.DEPTH(DEPTH), .PAGE(PAGE)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .buf_clr (buf_clr),
    .buf_we  (buf_we),
    .buf_idx (addr[PW-1:0]),
    .buf_din (rx_byte),
    .commit  (commit),
    .page_sel(addr[AW-1:PW]),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .buf_any (buf_any)
  );

  seeprom_busy #(.WIP_CYCLES(WIP_CYCLES)) u_busy (
    .clk  (clk),
    .rst_n(rst_n_s),
    .start(commit),
    .busy (wip)
  );

  assign spi_sdo    = sdo_q;
  assign spi_sdo_oe = !cs_s && (st == ST_RDATA || st == ST_STAT);
endmodule

// File: rtl/seeprom_slave_chk.sv
module seeprom_slave_chk
  import seeprom_pkg::*;
#(
  parameter int WIP_CYCLES = 1000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_rise,
  input logic        cs_fall,
  input logic        sck_fall,
  input logic        wip,
  input logic        wel,
  input logic        commit,
  input logic        buf_we,
  input seep_state_e st,
  input logic        spi_sdo,
  input logic        spi_sdo_oe
);
  localparam int CW = $clog2(WIP_CYCLES + 1) + 1;

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_cnt <= '0;
    else if (wip) hi_cnt <= hi_cnt + CW'(1);
    else          hi_cnt <= '0;
  end

  assert_wip_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> hi_cnt == CW'(WIP_CYCLES));

  assert_commit_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!wel && wip));

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !(st inside {ST_RADDR, ST_RDATA, ST_WADDR, ST_WDATA}));

  assert_oe_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !spi_sdo_oe);

  assert_sdo_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_fall) |=> $stable(spi_sdo));

  assert_buf_needs_wel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> wel);
endmodule

bind seeprom_slave seeprom_slave_chk #(.WIP_CYCLES(WIP_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .cs_rise   (cs_rise),
  .cs_fall   (cs_fall),
  .sck_fall  (sck_fall),
  .wip       (wip),
  .wel       (wel),
  .commit    (commit),
  .buf_we    (buf_we),
  .st        (st),
  .spi_sdo   (spi_sdo),
  .spi_sdo_oe(spi_sdo_oe)
);

// File: tb/seeprom_slave_bench.sv
module seeprom_slave_bench;
  localparam int WIPC = 1000;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  wire  sdo, oe;

  always #5 clk = ~clk;

  seeprom_slave #(.DEPTH(512), .PAGE(16), .WIP_CYCLES(WIPC)) u_seeprom_slave (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_sdi(sdi), .spi_sdo(sdo), .spi_sdo_oe(oe)
  );

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  bit oe_seen;
  logic [7:0] tx [0:599];
  logic [7:0] rx [0:599];
  logic [7:0] model [0:511];

  function automatic logic [7:0] fv(int a);
    return 8'((a * 37 + 11) ^ (a >> 2));
  endfunction

  task automatic clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xact(int nb, int extra);
    oe_seen = 1'b0;
    cs_n = 1'b0;
    clks(6);
    for (int i = 0; i < nb + ((extra > 0) ? 1 : 0); i++) begin
      for (int b = 7; b >= 0; b--) begin
        if (i == nb && (7 - b) >= extra) break;
        sdi = tx[i][b];
        clks(HALF);
        rx[i][b] = sdo;
        oe_seen = oe_seen | oe;
        sck = 1'b1;
        clks(HALF);
        sck = 1'b0;
      end
    end
    clks(HALF + 1);
    cs_n = 1'b1;
    clks(8);
  endtask

  task automatic clear_tx();
    for (int i = 0; i < 600; i++) tx[i] = 8'h00;
  endtask

  task automatic wren();
    clear_tx();
    tx[0] = 8'h06;
    xact(1, 0);
  endtask

  task automatic rdsr(output logic [7:0] s);
    clear_tx();
    tx[0] = 8'h05;
    xact(3, 0);
    s = rx[1];
  endtask

  task automatic rd(int a, int n);
    clear_tx();
    tx[0] = {4'h0, 1'(a >> 8), 3'b011};
    tx[1] = 8'(a);
    xact(n + 2, 0);
  endtask

  task automatic wr_hdr(int a);
    clear_tx();
    tx[0] = {4'h0, 1'(a >> 8), 3'b010};
    tx[1] = 8'(a);
  endtask

  logic [7:0] s;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    clks(5);
    rst_n = 1'b1;
    clks(5);

    // R1 R10: reset state
    chk(oe == 1'b0, "R1 oe after reset", int'(oe), 0);
    rdsr(s);
    chk(s == 8'h00, "R1 status after reset", s, 0);
    chk(rx[2] == 8'h00, "R2 repeated status", rx[2], 0);

    // fill whole array page by page
    for (int p = 0; p < 32; p++) begin
      wren();
      if (p == 0) begin
        rdsr(s);
        chk(s == 8'h02, "R3 WEL after WREN", s, 2);
        chk(rx[2] == 8'h02, "R2 status repeats", rx[2], 2);
      end
      wr_hdr(p * 16);
      for (int k = 0; k < 16; k++) begin
        tx[2 + k] = fv(p * 16 + k);
        model[p * 16 + k] = fv(p * 16 + k);
      end
      xact(18, 0);
      if (p == 0) begin
        rdsr(s);
        chk(s == 8'h01, "R8 busy and WEL cleared", s, 1);
      end
      clks(WIPC + 20);
      if (p == 0) begin
        rdsr(s);
        chk(s == 8'h00, "R8 busy released", s, 0);
      end
    end

    // R4 R5: full-array sequential read with wrap
    rd(0, 528);
    for (int k = 0; k < 528; k++)
      chk(rx[2 + k] == model[k % 512], "R5 sequential read", rx[2 + k], model[k % 512]);
    chk(oe == 1'b0, "R10 oe after deselect", int'(oe), 0);

    rd(9'h1FE, 4);
    chk(rx[2] == model[510], "R5 at 1FE", rx[2], model[510]);
    chk(rx[3] == model[511], "R5 at 1FF", rx[3], model[511]);
    chk(rx[4] == model[0], "R5 wrap to 000", rx[4], model[0]);
    chk(rx[5] == model[1], "R5 at 001", rx[5], model[1]);

    rd(9'h1A5, 1);
    chk(rx[2] == model[9'h1A5], "R4 A8 via opcode", rx[2], model[9'h1A5]);
    rd(9'h0A5, 1);
    chk(rx[2] == model[9'h0A5], "R4 low half", rx[2], model[9'h0A5]);

    // R6: 20 bytes into page 0x130 starting at 0x13C
    wren();
    wr_hdr(9'h13C);
    for (int k = 0; k < 20; k++) begin
      tx[2 + k] = 8'hA0 + 8'(k);
      model[9'h130 | ((12 + k) % 16)] = 8'hA0 + 8'(k);
    end
    xact(22, 0);
    clks(WIPC + 20);
    rd(9'h130, 16);
    for (int k = 0; k < 16; k++)
      chk(rx[2 + k] == model[9'h130 + k], "R6 page wrap", rx[2 + k], model[9'h130 + k]);

    // R7: deselect in the middle of a byte discards
    wren();
    wr_hdr(9'h050);
    tx[2] = 8'h11;
    tx[3] = 8'h22;
    tx[4] = 8'h33;
    xact(4, 3);
    rdsr(s);
    chk(s == 8'h00, "R7 abort clears WEL no busy", s, 0);
    rd(9'h050, 2);
    chk(rx[2] == model[9'h050], "R7 abort keeps data", rx[2], model[9'h050]);
    chk(rx[3] == model[9'h051], "R7 abort keeps data", rx[3], model[9'h051]);

    // R7: address only, no data byte
    wren();
    wr_hdr(9'h058);
    xact(2, 0);
    rdsr(s);
    chk(s == 8'h00, "R7 no data byte", s, 0);

    // R11: write without enable
    wr_hdr(9'h060);
    tx[2] = 8'h77;
    xact(3, 0);
    rdsr(s);
    chk(s == 8'h00, "R11 no busy", s, 0);
    rd(9'h060, 1);
    chk(rx[2] == model[9'h060], "R11 data unchanged", rx[2], model[9'h060]);

    // R3: enable and write in same selection
    clear_tx();
    tx[0] = 8'h06;
    tx[1] = 8'h02;
    tx[2] = 8'h70;
    tx[3] = 8'h55;
    xact(4, 0);
    rdsr(s);
    chk(s == 8'h00, "R3 same-selection write", s, 0);
    rd(9'h070, 1);
    chk(rx[2] == model[9'h070], "R3 data unchanged", rx[2], model[9'h070]);

    // R9: instructions blocked while busy
    wren();
    wr_hdr(9'h080);
    tx[2] = 8'h5A;
    xact(3, 0);
    model[9'h080] = 8'h5A;
    rdsr(s);
    chk(s == 8'h01, "R9 status read while busy", s, 1);
    wren();
    rd(9'h080, 1);
    chk(oe_seen == 1'b0, "R9 read ignored while busy", int'(oe_seen), 0);
    rdsr(s);
    chk(s == 8'h01, "R9 WREN ignored while busy", s, 1);
    clks(WIPC + 20);
    rdsr(s);
    chk(s == 8'h00, "R8 busy ends", s, 0);
    rd(9'h080, 1);
    chk(rx[2] == 8'h5A, "R8 committed byte", rx[2], 8'h5A);

    // R12: unknown opcode
    clear_tx();
    tx[0] = 8'hFF;
    tx[1] = 8'h05;
    xact(3, 0);
    chk(oe_seen == 1'b0, "R12 unknown opcode silent", int'(oe_seen), 0);
    wren();
    clear_tx();
    tx[0] = 8'h3C;
    xact(1, 0);
    rdsr(s);
    chk(s == 8'h02, "R12 latch unchanged", s, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule